// File: doc/BRIEF.md
# Speculative Line Fill Buffer

This block parks cache lines brought in by loads that are still speculative, so that a fill cannot alter the L1 data cache before its load is known to be good. Every slot keeps a full line, the line address and the retire tag of the owning load. A load can be served from a slot whose address matches. The slot's contents reach the cache only after that tag retires. When that happens, the line goes out through the one cache write port, which it shares with store commits.

A squash discards every slot whose tag is younger than the squash tag. Those slots never reach the cache. Invalidation probes from other cores drop any slot that holds the probed line. The cache arrays, the coherence engine and the store queue are outside the block. They appear only as plain request ports.

Top module: `spec_fill_buf`

## Requirements
- R1: After reset, fill_ready_o is 1, lookup_hit_o is 0 for any address, and cache_wr_valid_o is 0.
- R2: A fill accepted in cycle t holds the whole 512-bit line. From cycle t+1, a lookup of the same line address returns lookup_hit_o=1 with lookup_data_o equal to the full filled line.
- R3: With all 8 slots occupied, fill_ready_o is 0. A fill presented then is ignored, so a later lookup of its address misses.
- R4: A slot whose tag has not retired never drives a cache write. Its line stays available to lookups.
- R5: A retire of tag T in cycle t, with no store commit in cycle t+1, writes the matching line in cycle t+1. That write has cache_wr_src_line_o=1 and cache_wr_be_o all ones. The slot is then freed, so a later lookup misses.
- R6: A store commit is written in the cycle it is presented, with cache_wr_src_line_o=0 and its own address, data and byte enables. A pending line write waits until the first cycle without a store commit.
- R7: A squash with tag S clears, at the next edge, every slot whose tag is greater than S as an unsigned number. Slots with tags less than or equal to S stay valid.
- R8: An invalidation for a line address clears every slot holding that address at the next edge. A later retire of that slot's tag produces no cache write.
- R9: If an invalidation hits a slot in the same cycle that the slot would be written to the cache, no write occurs and the slot is dropped.
- R10: When several retired slots wait, they are written one per cycle, lowest slot index first. Slots are allocated lowest free index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fill_valid_i | input | 1 | Incoming line fill |
| fill_addr_i | input | 26 | Line address of the fill |
| fill_tag_i | input | 4 | Retire tag of the owning load |
| fill_data_i | input | 512 | Full line data |
| fill_ready_o | output | 1 | A free slot exists; fill accepted |
| lookup_addr_i | input | 26 | Line address probed by a load |
| lookup_hit_o | output | 1 | A valid slot holds the probed line |
| lookup_data_o | output | 512 | Line of the hitting slot, zero on miss |
| retire_valid_i | input | 1 | A load retires |
| retire_tag_i | input | 4 | Tag of the retiring load |
| squash_valid_i | input | 1 | Pipeline squash |
| squash_tag_i | input | 4 | Squash point; greater tags are discarded |
| inval_valid_i | input | 1 | Coherence invalidation probe |
| inval_addr_i | input | 26 | Line address being invalidated |
| store_valid_i | input | 1 | Store commit request |
| store_addr_i | input | 26 | Store line address |
| store_data_i | input | 512 | Store data |
| store_be_i | input | 64 | Store byte enables |
| cache_wr_valid_o | output | 1 | Cache write port strobe |
| cache_wr_src_line_o | output | 1 | 1 = buffered line, 0 = store commit |
| cache_wr_addr_o | output | 26 | Cache write line address |
| cache_wr_data_o | output | 512 | Cache write data |
| cache_wr_be_o | output | 64 | Cache write byte enables |

## Verification
A store commit reaches the write port combinationally in the cycle it is driven. A buffered line appears one cycle after its retire, because the retired flag is registered, and later if store commits occupy the port. Fills, squashes and invalidations show up on lookups from the cycle after they are presented. The driver presents inputs just after the rising edge and queues each expected write with the exact cycle number it is due. The monitor samples at the falling edge and compares address, source, data, byte enables and cycle. Any write the queue does not expect counts as a failure.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam int TAG_MAX_W = 16;

  typedef enum logic {
    WR_SRC_STORE = 1'b0,
    WR_SRC_LINE  = 1'b1
  } wr_src_e;

  // unsigned age order: greater tag is younger
  function automatic logic tag_younger(input logic [TAG_MAX_W-1:0] a,
                                       input logic [TAG_MAX_W-1:0] ref_tag);
    return a > ref_tag;
  endfunction
endpackage

// File: rtl/sfb_pick.sv
module sfb_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/sfb_store.sv
module sfb_store
  import sfb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int LADDR_W = 26,
  parameter int TAG_W   = 4,
  parameter int LINE_W  = 512,
  parameter int IW      = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fill_en_i,
  input  logic [IW-1:0]      fill_idx_i,
  input  logic [LADDR_W-1:0] fill_addr_i,
  input  logic [TAG_W-1:0]   fill_tag_i,
  input  logic [LINE_W-1:0]  fill_data_i,
  input  logic               retire_valid_i,
  input  logic [TAG_W-1:0]   retire_tag_i,
  input  logic               squash_valid_i,
  input  logic [TAG_W-1:0]   squash_tag_i,
  input  logic               inval_valid_i,
  input  logic [LADDR_W-1:0] inval_addr_i,
  input  logic               commit_en_i,
  input  logic [IW-1:0]      commit_idx_i,
  output logic [ENTRIES-1:0] valid_o,
  output logic [ENTRIES-1:0] cand_o,
  output logic [LADDR_W-1:0] addr_o [ENTRIES],
  output logic [LINE_W-1:0]  data_o [ENTRIES]
);
  logic [ENTRIES-1:0] valid_q, retired_q, kill;
  logic [LADDR_W-1:0] addr_q [ENTRIES];
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [LINE_W-1:0]  data_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sq_hit, inv_hit, ret_hit;
    assign sq_hit  = squash_valid_i &
                     tag_younger(TAG_MAX_W'(tag_q[g]), TAG_MAX_W'(squash_tag_i));
    assign inv_hit = inval_valid_i & (addr_q[g] == inval_addr_i);
    assign ret_hit = retire_valid_i & (tag_q[g] == retire_tag_i);
    assign kill[g] = valid_q[g] & (sq_hit | inv_hit);
    // a killed slot is never offered to the write port
    assign cand_o[g] = valid_q[g] & retired_q[g] & ~kill[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g]   <= 1'b0;
        retired_q[g] <= 1'b0;
        addr_q[g]    <= '0;
        tag_q[g]     <= '0;
        data_q[g]    <= '0;
      end else if (kill[g]) begin
        valid_q[g]   <= 1'b0;
        retired_q[g] <= 1'b0;
      end else if (commit_en_i && commit_idx_i == IW'(g)) begin
        valid_q[g]   <= 1'b0;
        retired_q[g] <= 1'b0;
      end else if (fill_en_i && fill_idx_i == IW'(g)) begin
        valid_q[g]   <= 1'b1;
        retired_q[g] <= 1'b0;
        addr_q[g]    <= fill_addr_i;
        tag_q[g]     <= fill_tag_i;
        data_q[g]    <= fill_data_i;
      end else if (valid_q[g] && ret_hit) begin
        retired_q[g] <= 1'b1;
      end
    end

    assign addr_o[g] = addr_q[g];
    assign data_o[g] = data_q[g];
  end

  assign valid_o = valid_q;

  AST_COMMIT_RETIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_en_i |-> (valid_q[commit_idx_i] && retired_q[commit_idx_i])); // R4
  AST_FILL_FREE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |-> !valid_q[fill_idx_i]); // R3
endmodule

// File: rtl/sfb_wr_arb.sv
module sfb_wr_arb
  import sfb_pkg::*;
#(
  parameter int LADDR_W = 26,
  parameter int LINE_W  = 512,
  parameter int BE_W    = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               store_valid_i,
  input  logic [LADDR_W-1:0] store_addr_i,
  input  logic [LINE_W-1:0]  store_data_i,
  input  logic [BE_W-1:0]    store_be_i,
  input  logic               line_req_i,
  input  logic [LADDR_W-1:0] line_addr_i,
  input  logic [LINE_W-1:0]  line_data_i,
  output logic               line_grant_o,
  output logic               wr_valid_o,
  output logic               wr_src_line_o,
  output logic [LADDR_W-1:0] wr_addr_o,
  output logic [LINE_W-1:0]  wr_data_o,
  output logic [BE_W-1:0]    wr_be_o
);
  wr_src_e src;

  // stores always win; a buffered line retries the next free cycle
  always_comb begin
    src = store_valid_i ? WR_SRC_STORE : WR_SRC_LINE;
    line_grant_o = line_req_i & ~store_valid_i;
    wr_valid_o   = store_valid_i | line_req_i;
    if (src == WR_SRC_STORE) begin
      wr_addr_o = store_addr_i;
      wr_data_o = store_data_i;
      wr_be_o   = store_be_i;
    end else begin
      wr_addr_o = line_addr_i;
      wr_data_o = line_data_i;
      wr_be_o   = '1;
    end
  end
  assign wr_src_line_o = (src == WR_SRC_LINE);

  AST_STORE_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_valid_i |-> (wr_valid_o && !wr_src_line_o && wr_addr_o == store_addr_i)); // R6
endmodule

// File: rtl/spec_fill_buf.sv
module spec_fill_buf #(
  parameter int ENTRIES    = 8,
  parameter int LINE_BYTES = 64,
  parameter int PADDR_W    = 32,
  parameter int TAG_W      = 4,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int LADDR_W   = PADDR_W - $clog2(LINE_BYTES),
  localparam int IW        = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fill_valid_i,
  input  logic [LADDR_W-1:0] fill_addr_i,
  input  logic [TAG_W-1:0]   fill_tag_i,
  input  logic [LINE_W-1:0]  fill_data_i,
  output logic               fill_ready_o,
  input  logic [LADDR_W-1:0] lookup_addr_i,
  output logic               lookup_hit_o,
  output logic [LINE_W-1:0]  lookup_data_o,
  input  logic               retire_valid_i,
  input  logic [TAG_W-1:0]   retire_tag_i,
  input  logic               squash_valid_i,
  input  logic [TAG_W-1:0]   squash_tag_i,
  input  logic               inval_valid_i,
  input  logic [LADDR_W-1:0] inval_addr_i,
  input  logic               store_valid_i,
  input  logic [LADDR_W-1:0] store_addr_i,
  input  logic [LINE_W-1:0]  store_data_i,
  input  logic [LINE_BYTES-1:0] store_be_i,
  output logic               cache_wr_valid_o,
  output logic               cache_wr_src_line_o,
  output logic [LADDR_W-1:0] cache_wr_addr_o,
  output logic [LINE_W-1:0]  cache_wr_data_o,
  output logic [LINE_BYTES-1:0] cache_wr_be_o
);
  logic [ENTRIES-1:0] valid, cand, look_vec;
  logic [LADDR_W-1:0] addr [ENTRIES];
  logic [LINE_W-1:0]  data [ENTRIES];
  logic               free_found, look_found, cmt_found, cmt_grant;
  logic [IW-1:0]      free_idx, look_idx, cmt_idx;

  sfb_store #(
    .ENTRIES(ENTRIES), .LADDR_W(LADDR_W), .TAG_W(TAG_W), .LINE_W(LINE_W), .IW(IW)
  ) u_store (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fill_en_i      (fill_valid_i & free_found),
    .fill_idx_i     (free_idx),
    .fill_addr_i    (fill_addr_i),
    .fill_tag_i     (fill_tag_i),
    .fill_data_i    (fill_data_i),
    .retire_valid_i (retire_valid_i),
    .retire_tag_i   (retire_tag_i),
    .squash_valid_i (squash_valid_i),
    .squash_tag_i   (squash_tag_i),
    .inval_valid_i  (inval_valid_i),
    .inval_addr_i   (inval_addr_i),
    .commit_en_i    (cmt_grant),
    .commit_idx_i   (cmt_idx),
    .valid_o        (valid),
    .cand_o         (cand),
    .addr_o         (addr),
    .data_o         (data)
  );

  sfb_pick #(.N(ENTRIES), .IW(IW)) u_pick_free (
    .req_i(~valid), .found_o(free_found), .idx_o(free_idx));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_look
    assign look_vec[g] = valid[g] & (addr[g] == lookup_addr_i);
  end

  sfb_pick #(.N(ENTRIES), .IW(IW)) u_pick_look (
    .req_i(look_vec), .found_o(look_found), .idx_o(look_idx));

  sfb_pick #(.N(ENTRIES), .IW(IW)) u_pick_cmt (
    .req_i(cand), .found_o(cmt_found), .idx_o(cmt_idx));

  sfb_wr_arb #(.LADDR_W(LADDR_W), .LINE_W(LINE_W), .BE_W(LINE_BYTES)) u_arb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .store_valid_i (store_valid_i),
    .store_addr_i  (store_addr_i),
    .store_data_i  (store_data_i),
    .store_be_i    (store_be_i),
    .line_req_i    (cmt_found),
    .line_addr_i   (addr[cmt_idx]),
    .line_data_i   (data[cmt_idx]),
    .line_grant_o  (cmt_grant),
    .wr_valid_o    (cache_wr_valid_o),
    .wr_src_line_o (cache_wr_src_line_o),
    .wr_addr_o     (cache_wr_addr_o),
    .wr_data_o     (cache_wr_data_o),
    .wr_be_o       (cache_wr_be_o)
  );

  assign fill_ready_o  = free_found;
  assign lookup_hit_o  = look_found;
  assign lookup_data_o = look_found ? data[look_idx] : '0;

  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_ready_o |-> ($countones(valid) == ENTRIES)); // R3
  AST_INVAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inval_valid_i && cache_wr_valid_o && cache_wr_src_line_o)
      |-> (cache_wr_addr_o != inval_addr_i)); // R9
  AST_LINE_WR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_wr_valid_o && cache_wr_src_line_o) |-> (&cache_wr_be_o)); // R5
endmodule

// File: tb/spec_fill_buf_tb_top.sv
module spec_fill_buf_tb_top;
  localparam int LW = 512;
  localparam int AW = 26;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic fill_valid_i = 0, retire_valid_i = 0, squash_valid_i = 0;
  logic inval_valid_i = 0, store_valid_i = 0;
  logic [AW-1:0] fill_addr_i = '0, lookup_addr_i = '0, inval_addr_i = '0, store_addr_i = '0;
  logic [3:0] fill_tag_i = '0, retire_tag_i = '0, squash_tag_i = '0;
  logic [LW-1:0] fill_data_i = '0, store_data_i = '0;
  logic [63:0] store_be_i = '0;
  logic fill_ready_o, lookup_hit_o, cache_wr_valid_o, cache_wr_src_line_o;
  logic [LW-1:0] lookup_data_o, cache_wr_data_o;
  logic [AW-1:0] cache_wr_addr_o;
  logic [63:0] cache_wr_be_o;

  always #10 clk = ~clk;

  spec_fill_buf dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .fill_valid_i(fill_valid_i), .fill_addr_i(fill_addr_i), .fill_tag_i(fill_tag_i),
    .fill_data_i(fill_data_i), .fill_ready_o(fill_ready_o),
    .lookup_addr_i(lookup_addr_i), .lookup_hit_o(lookup_hit_o), .lookup_data_o(lookup_data_o),
    .retire_valid_i(retire_valid_i), .retire_tag_i(retire_tag_i),
    .squash_valid_i(squash_valid_i), .squash_tag_i(squash_tag_i),
    .inval_valid_i(inval_valid_i), .inval_addr_i(inval_addr_i),
    .store_valid_i(store_valid_i), .store_addr_i(store_addr_i),
    .store_data_i(store_data_i), .store_be_i(store_be_i),
    .cache_wr_valid_o(cache_wr_valid_o), .cache_wr_src_line_o(cache_wr_src_line_o),
    .cache_wr_addr_o(cache_wr_addr_o), .cache_wr_data_o(cache_wr_data_o),
    .cache_wr_be_o(cache_wr_be_o)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic          src_line;
    logic [LW-1:0] data;
    logic [63:0]   be;
    int            cyc;
    string         req;
  } wr_item_t;

  wr_item_t exp_q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R4";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [LW-1:0] pat(input int s);
    logic [LW-1:0] r;
    for (int k = 0; k < 16; k++) r[k*32 +: 32] = (32'(s) * 32'h9E3779B1) ^ 32'(k);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every cache write must match the head of the expectation queue
  always @(negedge clk) begin
    if (rst_ni && cache_wr_valid_o) begin
      if (exp_q.size() == 0) begin
        check(0, cur_req, {38'(0), cache_wr_addr_o}, 64'hDEAD);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        check(cache_wr_addr_o == e.addr && cache_wr_src_line_o == e.src_line &&
              cache_wr_data_o == e.data && cache_wr_be_o == e.be && cyc == e.cyc,
              e.req, {6'(0), cache_wr_src_line_o, 31'(cyc), cache_wr_addr_o},
              {6'(0), e.src_line, 31'(e.cyc), e.addr});
      end
    end
  end

  task automatic exp_line(input logic [AW-1:0] a, input int s, input int c, input string r);
    exp_q.push_back('{addr: a, src_line: 1'b1, data: pat(s), be: '1, cyc: c, req: r});
  endtask

  task automatic exp_store(input logic [AW-1:0] a, input int s, input int c, input string r);
    exp_q.push_back('{addr: a, src_line: 1'b0, data: pat(s), be: 64'h00FF, cyc: c, req: r});
  endtask

  task automatic cyc_begin();
    @(posedge clk); #1;
    fill_valid_i = 0; retire_valid_i = 0; squash_valid_i = 0;
    inval_valid_i = 0; store_valid_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc_begin();
  endtask

  task automatic do_fill(input logic [AW-1:0] a, input logic [3:0] t, input int s);
    cyc_begin();
    fill_valid_i = 1; fill_addr_i = a; fill_tag_i = t; fill_data_i = pat(s);
  endtask

  task automatic do_retire(input logic [3:0] t);
    cyc_begin();
    retire_valid_i = 1; retire_tag_i = t;
  endtask

  task automatic look(input logic [AW-1:0] a, input bit hit, input int s, input string r);
    cyc_begin();
    lookup_addr_i = a;
    @(negedge clk);
    check(lookup_hit_o == hit, r, 64'(lookup_hit_o), 64'(hit));
    if (hit) check(lookup_data_o == pat(s), r, lookup_data_o[63:0], pat(s)[63:0]);
  endtask

  localparam logic [AW-1:0] A0 = 26'h0001000;
  localparam logic [AW-1:0] BB = 26'h0002000;
  localparam logic [AW-1:0] XX = 26'h0003000;
  localparam logic [AW-1:0] D0 = 26'h0004000;
  localparam logic [AW-1:0] EE = 26'h0005000;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    // R1 reset state
    lookup_addr_i = A0;
    @(negedge clk);
    check(fill_ready_o == 1, "R1", 64'(fill_ready_o), 64'd1);
    check(lookup_hit_o == 0, "R1", 64'(lookup_hit_o), 64'd0);
    check(cache_wr_valid_o == 0, "R1", 64'(cache_wr_valid_o), 64'd0);

    // R2 fill then lookup; R4 no write before retire
    cur_req = "R4";
    do_fill(A0, 4'd1, 11);
    look(A0, 1, 11, "R2");
    idle(3);
    look(A0, 1, 11, "R4");
    // R5 retire then write one cycle later, slot freed
    do_retire(4'd1);
    exp_line(A0, 11, cyc + 1, "R5");
    idle(2);
    look(A0, 0, 0, "R5");

    // R3 fill all slots
    for (int i = 0; i < 8; i++) do_fill(BB + AW'(i), 4'(i), 20 + i);
    cyc_begin();
    fill_valid_i = 1; fill_addr_i = XX; fill_tag_i = 4'd8; fill_data_i = pat(99);
    @(negedge clk);
    check(fill_ready_o == 0, "R3", 64'(fill_ready_o), 64'd0);
    look(XX, 0, 0, "R3");
    look(BB + 7, 1, 27, "R3");

    // R7 squash tag 3 clears tags 4..7
    cur_req = "R7";
    cyc_begin();
    squash_valid_i = 1; squash_tag_i = 4'd3;
    for (int i = 0; i < 4; i++) look(BB + AW'(i), 1, 20 + i, "R7");
    for (int i = 4; i < 8; i++) look(BB + AW'(i), 0, 0, "R7");
    @(negedge clk);
    check(fill_ready_o == 1, "R7", 64'(fill_ready_o), 64'd1);

    // R6 store commits win the port; line waits
    do_retire(4'd0);
    exp_store(26'h0100, 101, cyc + 1, "R6");
    exp_store(26'h0101, 102, cyc + 2, "R6");
    exp_line(BB, 20, cyc + 3, "R6");
    cyc_begin();
    store_valid_i = 1; store_addr_i = 26'h0100; store_data_i = pat(101); store_be_i = 64'h00FF;
    cyc_begin();
    store_valid_i = 1; store_addr_i = 26'h0101; store_data_i = pat(102); store_be_i = 64'h00FF;
    idle(3);

    // R5 back-to-back retires
    do_retire(4'd1);
    exp_line(BB + 1, 21, cyc + 1, "R5");
    do_retire(4'd2);
    exp_line(BB + 2, 22, cyc + 1, "R5");
    idle(3);

    // R10 two slots, same tag: lowest index first
    do_fill(D0, 4'd9, 50);
    do_fill(D0 + 1, 4'd9, 51);
    do_retire(4'd9);
    exp_line(D0, 50, cyc + 1, "R10");
    exp_line(D0 + 1, 51, cyc + 2, "R10");
    idle(4);

    // R8 invalidation clears slot; later retire writes nothing
    cur_req = "R8";
    cyc_begin();
    inval_valid_i = 1; inval_addr_i = BB + 3;
    look(BB + 3, 0, 0, "R8");
    do_retire(4'd3);
    idle(4);

    // R9 invalidation in the commit cycle drops the line
    cur_req = "R9";
    do_fill(EE, 4'd5, 60);
    do_retire(4'd5);
    cyc_begin();
    inval_valid_i = 1; inval_addr_i = EE;
    @(negedge clk);
    check(cache_wr_valid_o == 0, "R9", 64'(cache_wr_valid_o), 64'd0);
    look(EE, 0, 0, "R9");
    idle(3);

    check(exp_q.size() == 0, "R5", 64'(exp_q.size()), 64'd0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule